// File: doc/BRIEF.md
# GPIO Pad Control Register Bank

This block holds the per-pin pad configuration of one GPIO port. A small memory-mapped bus reads and writes eight-bit-wide (parameter `PINS`) control registers. These registers select, pin by pin, the data direction, software versus alternate-function ownership, open-drain mode, weak pull-up, weak pull-down and digital enable. The register contents drive per-pin control vectors that go straight to a pad model.

Some pins are marked protected by a parameter, typically pins shared with a debug function. These pins reset with digital enable on, and their ownership, pull and digital-enable bits can only be changed once a commit bit has been set for them. The commit register itself accepts writes only while a lock register is unlocked. Software unlocks it by writing a 32-bit key, and any other value written to the lock register locks it again. The pull-up and pull-down registers exclude each other: setting a pin's pull in one register clears that pin's pull in the other.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, direction, ownership, open-drain, pull-up and pull-down read 0. Digital enable reads the protected-pin mask (pins 2 and 3 by default, 0x0C). Lock reads 1, and commit reads the inverse of the protected mask (0xF3).
- R2: Direction (word 0, 1 = output) and open-drain (word 2) take the written low `PINS` bits for every pin, protected ones included, with no lock or commit gating. A cycle with `bus_en` low changes nothing.
- R3: Writing the pull-up register (word 3) clears the pull-down bit of every committed pin written with 1 and leaves all other pull-down bits unchanged.
- R4: Writing the pull-down register (word 4) clears the pull-up bit of every committed pin written with 1 and leaves all other pull-up bits unchanged.
- R5: No pin ever has its pull-up and pull-down bits set at the same time. Within one write, pull-down takes priority.
- R6: Writing 0x4C4F434B to the lock register (word 6) unlocks it, after which it reads 0. Writing any other value locks it, after which it reads 1.
- R7: While the lock register is locked, writes to the commit register (word 7) have no effect.
- R8: Commit bits of non-protected pins always read 1, whatever is written.
- R9: For a pin whose commit bit is 0, writes leave its ownership (word 1), pull-up, pull-down and digital-enable (word 5) bits unchanged. Once its commit bit is 1, those writes take effect.
- R10: The pad output vectors equal the register contents and change on the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| pin_dir | output | PINS | 1 = output |
| pin_alt | output | PINS | 1 = alternate-function ownership |
| pin_od | output | PINS | Open-drain enable |
| pin_pu | output | PINS | Weak pull-up enable |
| pin_pd | output | PINS | Weak pull-down enable |
| pin_den | output | PINS | Digital enable |

## Verification
A write is presented on one rising edge and takes effect on that same edge. Its register and pad outputs are therefore due one edge after the bus phase, with no further latency. Read data is combinational from the addressed register, so it is valid in the same cycle as the address. The bench drives every access at a falling edge and samples read data and pad vectors at the next falling edge. This places each sample half a cycle after the edge that updated the state. Lock, commit and pull-exclusivity effects are each checked through a read of the affected register in the cycle after the write that should, or should not, have changed it.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
    localparam int BUS_AW = 3;
    localparam int BUS_DW = 32;

    typedef enum logic [BUS_AW-1:0] {
        RA_DIR    = 3'd0,
        RA_ALT    = 3'd1,
        RA_OD     = 3'd2,
        RA_PU     = 3'd3,
        RA_PD     = 3'd4,
        RA_DEN    = 3'd5,
        RA_LOCK   = 3'd6,
        RA_COMMIT = 3'd7
    } reg_addr_e;

    localparam logic [BUS_DW-1:0] UNLOCK_KEY = 32'h4C4F434B;
endpackage

// File: rtl/gpio_lock_unit.sv
module gpio_lock_unit
    import gpio_pad_pkg::*;
#(
    parameter int              PINS      = 8,
    parameter logic [PINS-1:0] PROT_PINS = 8'h0C
) (
    input  logic              wr_lock,
    input  logic              wr_commit,
    input  logic [BUS_DW-1:0] wdata,
    input  logic              locked_q,
    input  logic [PINS-1:0]   commit_q,
    output logic              locked_d,
    output logic [PINS-1:0]   commit_d
);
    always_comb begin
        locked_d = locked_q;
        commit_d = commit_q;
        if (wr_lock) begin
            locked_d = (wdata != UNLOCK_KEY);
        end
        if (wr_commit && !locked_q) begin
            for (int i = 0; i < PINS; i++) begin
                commit_d[i] = PROT_PINS[i] ? wdata[i] : 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpio_pull_unit.sv
module gpio_pull_unit #(
    parameter int PINS = 8
) (
    input  logic            wr_pu,
    input  logic            wr_pd,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] commit_q,
    input  logic [PINS-1:0] pu_q,
    input  logic [PINS-1:0] pd_q,
    output logic [PINS-1:0] pu_d,
    output logic [PINS-1:0] pd_d
);
    logic [PINS-1:0] set_bits;

    always_comb begin
        set_bits = wdata & commit_q;
        pu_d     = pu_q;
        pd_d     = pd_q;
        if (wr_pu) begin
            pu_d = (pu_q & ~commit_q) | set_bits;
            pd_d = pd_q & ~set_bits;
        end
        // applied last so that pull-down has priority
        if (wr_pd) begin
            pd_d = (pd_d & ~commit_q) | set_bits;
            pu_d = pu_d & ~set_bits;
        end
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_pad_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic [BUS_AW-1:0] addr,
    input  logic [PINS-1:0]   dir_q,
    input  logic [PINS-1:0]   alt_q,
    input  logic [PINS-1:0]   od_q,
    input  logic [PINS-1:0]   pu_q,
    input  logic [PINS-1:0]   pd_q,
    input  logic [PINS-1:0]   den_q,
    input  logic [PINS-1:0]   commit_q,
    input  logic              locked_q,
    output logic [BUS_DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (reg_addr_e'(addr))
            RA_DIR:    rdata[PINS-1:0] = dir_q;
            RA_ALT:    rdata[PINS-1:0] = alt_q;
            RA_OD:     rdata[PINS-1:0] = od_q;
            RA_PU:     rdata[PINS-1:0] = pu_q;
            RA_PD:     rdata[PINS-1:0] = pd_q;
            RA_DEN:    rdata[PINS-1:0] = den_q;
            RA_LOCK:   rdata[0]        = locked_q;
            RA_COMMIT: rdata[PINS-1:0] = commit_q;
            default:   rdata           = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int              PINS      = 8,
    parameter logic [PINS-1:0] PROT_PINS = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic [PINS-1:0]   pin_dir,
    output logic [PINS-1:0]   pin_alt,
    output logic [PINS-1:0]   pin_od,
    output logic [PINS-1:0]   pin_pu,
    output logic [PINS-1:0]   pin_pd,
    output logic [PINS-1:0]   pin_den
);
    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] alt;
        logic [PINS-1:0] od;
        logic [PINS-1:0] pu;
        logic [PINS-1:0] pd;
        logic [PINS-1:0] den;
        logic [PINS-1:0] commit;
        logic            locked;
    } pad_regs_t;

    localparam pad_regs_t RESET_REGS = '{
        dir: '0, alt: '0, od: '0, pu: '0, pd: '0,
        den: PROT_PINS, commit: ~PROT_PINS, locked: 1'b1
    };

    pad_regs_t st_d, st_q;

    logic            wr_any;
    logic            wr_lock, wr_commit, wr_pu, wr_pd;
    logic [PINS-1:0] wd;
    logic [PINS-1:0] pu_n, pd_n, commit_n;
    logic            locked_n;

    assign wr_any    = bus_en && bus_wr;
    assign wr_lock   = wr_any && (bus_addr == RA_LOCK);
    assign wr_commit = wr_any && (bus_addr == RA_COMMIT);
    assign wr_pu     = wr_any && (bus_addr == RA_PU);
    assign wr_pd     = wr_any && (bus_addr == RA_PD);
    assign wd        = bus_wdata[PINS-1:0];

    gpio_lock_unit #(.PINS(PINS), .PROT_PINS(PROT_PINS)) u_lock (
        .wr_lock   (wr_lock),
        .wr_commit (wr_commit),
        .wdata     (bus_wdata),
        .locked_q  (st_q.locked),
        .commit_q  (st_q.commit),
        .locked_d  (locked_n),
        .commit_d  (commit_n)
    );

    gpio_pull_unit #(.PINS(PINS)) u_pull (
        .wr_pu    (wr_pu),
        .wr_pd    (wr_pd),
        .wdata    (wd),
        .commit_q (st_q.commit),
        .pu_q     (st_q.pu),
        .pd_q     (st_q.pd),
        .pu_d     (pu_n),
        .pd_d     (pd_n)
    );

    gpio_read_mux #(.PINS(PINS)) u_rd (
        .addr     (bus_addr),
        .dir_q    (st_q.dir),
        .alt_q    (st_q.alt),
        .od_q     (st_q.od),
        .pu_q     (st_q.pu),
        .pd_q     (st_q.pd),
        .den_q    (st_q.den),
        .commit_q (st_q.commit),
        .locked_q (st_q.locked),
        .rdata    (bus_rdata)
    );

    always_comb begin
        st_d        = st_q;
        st_d.pu     = pu_n;
        st_d.pd     = pd_n;
        st_d.commit = commit_n;
        st_d.locked = locked_n;
        if (wr_any) begin
            unique case (reg_addr_e'(bus_addr))
                RA_DIR: st_d.dir = wd;
                RA_OD:  st_d.od  = wd;
                RA_ALT: st_d.alt = (st_q.alt & ~st_q.commit) | (wd & st_q.commit);
                RA_DEN: st_d.den = (st_q.den & ~st_q.commit) | (wd & st_q.commit);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_REGS;
        else        st_q <= st_d;
    end

    assign pin_dir = st_q.dir;
    assign pin_alt = st_q.alt;
    assign pin_od  = st_q.od;
    assign pin_pu  = st_q.pu;
    assign pin_pd  = st_q.pd;
    assign pin_den = st_q.den;

    // R5
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pu & st_q.pd) == '0);

    // R3
    pu_clears_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pu && !wr_pd) |=> ((st_q.pd & $past(wd & st_q.commit)) == '0));

    // R6
    lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && bus_wdata == UNLOCK_KEY) |=> !st_q.locked);

    // R7
    commit_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> $stable(st_q.commit));

    // R8
    commit_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(st_q.commit & ~PROT_PINS));

    generate
        for (genvar g = 0; g < PINS; g++) begin : g_prot_chk
            // R9
            uncommitted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !st_q.commit[g] |=> ($stable(st_q.alt[g]) && $stable(st_q.den[g])
                                     && $stable(st_q.pu[g]) && $stable(st_q.pd[g])));
        end
    endgenerate
endmodule

// File: tb/tb_gpio_pad_ctrl.sv
module tb_gpio_pad_ctrl;
    import gpio_pad_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_dir, pin_alt, pin_od, pin_pu, pin_pd, pin_den;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gpio_pad_ctrl #(.PINS(8), .PROT_PINS(8'h0C)) dut (
        .clk, .rst_n, .bus_en, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .pin_dir, .pin_alt, .pin_od, .pin_pu, .pin_pd, .pin_den
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_en = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 dir", 3'd0, 32'h0);
        rd_chk("R1 alt", 3'd1, 32'h0);
        rd_chk("R1 od", 3'd2, 32'h0);
        rd_chk("R1 pu", 3'd3, 32'h0);
        rd_chk("R1 pd", 3'd4, 32'h0);
        rd_chk("R1 den", 3'd5, 32'h0C);
        rd_chk("R1 lock", 3'd6, 32'h1);
        rd_chk("R1 commit", 3'd7, 32'hF3);
        check("R1 pin_den", {24'h0, pin_den}, 32'h0C);
    endtask

    task automatic t_dir_od();
        wr(3'd0, 32'hFFFF_FFA5);
        rd_chk("R2 dir", 3'd0, 32'hA5);
        check("R10 pin_dir", {24'h0, pin_dir}, 32'hA5);
        wr(3'd2, 32'h3C);
        rd_chk("R2 od", 3'd2, 32'h3C);
        check("R10 pin_od", {24'h0, pin_od}, 32'h3C);
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h00;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_chk("R2 no-enable write ignored", 3'd0, 32'hA5);
    endtask

    task automatic t_pull();
        wr(3'd3, 32'hF0);
        rd_chk("R3 pu set", 3'd3, 32'hF0);
        wr(3'd4, 32'h30);
        rd_chk("R4 pd set", 3'd4, 32'h30);
        rd_chk("R4 pu cleared", 3'd3, 32'hC0);
        wr(3'd3, 32'h11);
        rd_chk("R3 pu", 3'd3, 32'h11);
        rd_chk("R3 pd cleared", 3'd4, 32'h20);
        check("R5 exclusive", {24'h0, pin_pu & pin_pd}, 32'h0);
        check("R10 pin_pd", {24'h0, pin_pd}, 32'h20);
    endtask

    task automatic t_protect();
        wr(3'd1, 32'hFF);
        rd_chk("R9 alt gated", 3'd1, 32'hF3);
        wr(3'd5, 32'h00);
        rd_chk("R9 den gated", 3'd5, 32'h0C);
        wr(3'd7, 32'hFF);
        rd_chk("R7 commit locked", 3'd7, 32'hF3);
        wr(3'd6, 32'h1234_5678);
        rd_chk("R6 wrong key", 3'd6, 32'h1);
        wr(3'd6, UNLOCK_KEY);
        rd_chk("R6 unlocked", 3'd6, 32'h0);
        wr(3'd7, 32'h04);
        rd_chk("R8 commit", 3'd7, 32'hF7);
        wr(3'd1, 32'hFF);
        rd_chk("R9 alt committed", 3'd1, 32'hF7);
        check("R10 pin_alt", {24'h0, pin_alt}, 32'hF7);
        wr(3'd5, 32'h00);
        rd_chk("R9 den committed", 3'd5, 32'h08);
        wr(3'd3, 32'h04);
        rd_chk("R9 pu committed", 3'd3, 32'h04);
        wr(3'd4, 32'h0C);
        rd_chk("R9 pd pin3 gated", 3'd4, 32'h04);
        rd_chk("R4 pu cleared pin2", 3'd3, 32'h00);
        wr(3'd6, 32'h0);
        rd_chk("R6 relocked", 3'd6, 32'h1);
        wr(3'd7, 32'hFF);
        rd_chk("R7 commit relocked", 3'd7, 32'hF7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir_od();
        t_pull();
        t_protect();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule